// File: doc/BRIEF.md
# Transfer Descriptor Fetch Sequencer

This block sits in front of a data-transfer engine and turns an activation request into a fully unpacked transfer descriptor. Five hardware sources raise level requests: two receive and two transmit events from two serial channels, and a compare-match event. Software can also request an activation, and supplies an 8-bit vector value with that request. When the sequencer is idle it picks the highest-priority enabled request and reads that source's 16-bit vector-table entry. It joins a 16-bit base value, held as the upper half, to that entry, held as the lower half, to form the descriptor start address. It then walks the descriptor over a 16-bit read port.

The first descriptor word carries the transfer mode. The mode decides which of the following words are read. Padding words are never fetched. When the last word arrives the sequencer presents all fields with a one-cycle valid pulse. An illegal mode ends the walk at once with a one-cycle error pulse. The consumer is expected to clear the source's request before the sequencer returns to idle.

Top module: `xds_seq`

## Requirements
- R1: Simultaneous enabled requests are served in fixed priority src_req[0] (serial 0 receive) > src_req[1] (serial 0 transmit) > src_req[2] (serial 1 receive) > src_req[3] (serial 1 transmit) > src_req[4] (compare-match) > sw_req. desc_origin reports the winner as its src_req index 0..4, or 5 for software.
- R2: A hardware request with its enable low is ignored and starts no memory read. The enables are en_serial[3] for src_req[0], en_serial[2] for src_req[1], en_serial[1] for src_req[2], en_serial[0] for src_req[3], and en_cmatch for src_req[4]. Software requests have no enable.
- R3: The first read of an activation is the vector entry at byte address 0x438 + 2*index for hardware source index, or 0x400 + sw_vec for software, with mem_addr[31:16] = 0. The descriptor start address is {base_hi sampled at acceptance, returned vector word}.
- R4: Mode bits [1:0] = 00 (normal) read start+0, +2, +8, +10, +12, +14, in that order.
- R5: Mode 01 (repeat) read +0, +2, +4, +6, +8, +10, +12, +14, and form desc_init = {word at +4, word at +6}.
- R6: Mode 10 (block) read +0, +2, +6, +8, +10, +12, +14, and take desc_cnt_b from the word at +6.
- R7: Each 32-bit field is formed as {word at lower address, word at address+2}. desc_src_addr comes from +8/+10 and desc_dst_addr from +12/+14. desc_mode and desc_cnt_a come from +0 and +2. desc_init is zero unless the mode is repeat, and desc_cnt_b is zero unless the mode is block.
- R8: Mode 11 makes desc_err high for one cycle, in the cycle after the mode word's handshake. No further read is issued and desc_valid stays low.
- R9: Once mem_req is high it stays high with mem_addr stable until a cycle with mem_ready high, which completes the read. Only one read is outstanding at any time.
- R10: desc_valid is a one-cycle pulse in the cycle after the last handshake, with all fields valid. During a valid or error pulse mem_req is low. A new activation starts at the earliest one cycle after the pulse.
- R11: After reset mem_req, desc_valid and desc_err are low and all field outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 5 | Hardware activation requests, index 0 highest |
| en_serial | input | 4 | Enables for the four serial sources |
| en_cmatch | input | 1 | Enable for the compare-match source |
| sw_req | input | 1 | Software activation request |
| sw_vec | input | 8 | Software vector value |
| base_hi | input | 16 | Upper half of the descriptor start address |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_ready | input | 1 | Read completes in this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| desc_valid | output | 1 | Descriptor fields valid pulse |
| desc_err | output | 1 | Illegal mode pulse |
| desc_origin | output | 3 | Winning source id |
| desc_mode | output | 16 | Mode word |
| desc_cnt_a | output | 16 | First count |
| desc_cnt_b | output | 16 | Second count (block mode) |
| desc_init | output | 32 | Initial address (repeat mode) |
| desc_src_addr | output | 32 | Source address |
| desc_dst_addr | output | 32 | Destination address |

## Verification
The main function is tried with a single request in each of the three legal modes. These runs tell the three address walks apart, and the padding words hold junk, so a fetched pad shows up both in the order of read addresses and in the zeroed fields. A software request with an odd vector value and a different base separates the two vector formulas and the base join. All six requests raised at once, then dropped one by one, show the full priority order. Cases with some enables cleared separate enable gating from priority, and an illegal mode word in the middle of the priority chain shows that the walk stops early without disturbing later activations. Memory latency varies randomly, so that address hold and single-outstanding behaviour are exercised.

// File: rtl/xds_pkg.sv
package xds_pkg;

  localparam int N_HW   = 5;
  localparam int SRC_W  = 3;
  localparam int OFF_W  = 4;

  typedef enum logic [1:0] {
    M_NORMAL = 2'b00,
    M_REPEAT = 2'b01,
    M_BLOCK  = 2'b10,
    M_BAD    = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_VEC  = 2'b01,
    ST_DESC = 2'b10
  } seq_state_e;

  // Vector table byte address for a winning source id.
  function automatic logic [15:0] vec_addr(input logic [SRC_W-1:0] id,
                                           input logic [7:0] swv,
                                           input logic [15:0] hw_base,
                                           input logic [15:0] sw_base);
    if (int'(id) == N_HW)
      return sw_base + {8'h00, swv};
    else
      return hw_base + {12'h000, id, 1'b0};
  endfunction

  // Next descriptor word offset after the word at 'off'; padding is skipped.
  function automatic logic [OFF_W-1:0] next_off(input logic [1:0] mode,
                                                input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] n;
    case (off)
      4'd2: begin
        case (mode)
          M_REPEAT: n = 4'd4;
          M_BLOCK:  n = 4'd6;
          default:  n = 4'd8;
        endcase
      end
      default: n = off + 4'd2;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/xds_arbiter.sv
module xds_arbiter
  import xds_pkg::*;
#(
  parameter int N = N_HW
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     gate,
  input  logic             sw_req,
  output logic             any,
  output logic [SRC_W-1:0] win
);
  logic [N-1:0] live;

  generate
    for (genvar g = 0; g < N; g++) begin : g_gate
      assign live[g] = req[g] & gate[g];
    end
  endgenerate

  always_comb begin
    any = sw_req;
    win = SRC_W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        any = 1'b1;
        win = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/xds_fields.sv
module xds_fields
  import xds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [OFF_W-1:0] off,
  input  logic [15:0]      wdata,
  output logic [1:0]       mode_bits,
  output logic [15:0]      f_mode,
  output logic [15:0]      f_cnt_a,
  output logic [15:0]      f_cnt_b,
  output logic [31:0]      f_init,
  output logic [31:0]      f_src,
  output logic [31:0]      f_dst
);
  assign mode_bits = f_mode[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_mode  <= '0;
      f_cnt_a <= '0;
      f_cnt_b <= '0;
      f_init  <= '0;
      f_src   <= '0;
      f_dst   <= '0;
    end else if (clr) begin
      f_mode  <= '0;
      f_cnt_a <= '0;
      f_cnt_b <= '0;
      f_init  <= '0;
      f_src   <= '0;
      f_dst   <= '0;
    end else if (wr) begin
      case (off)
        4'd0:  f_mode  <= wdata;
        4'd2:  f_cnt_a <= wdata;
        4'd4:  f_init[31:16] <= wdata;
        4'd6: begin
          if (f_mode[1:0] == M_REPEAT) f_init[15:0] <= wdata;
          else                         f_cnt_b      <= wdata;
        end
        4'd8:  f_src[31:16] <= wdata;
        4'd10: f_src[15:0]  <= wdata;
        4'd12: f_dst[31:16] <= wdata;
        4'd14: f_dst[15:0]  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xds_seq.sv
module xds_seq
  import xds_pkg::*;
#(
  parameter logic [15:0] VEC_HW_BASE = 16'h0438,
  parameter logic [15:0] VEC_SW_BASE = 16'h0400,
  parameter int          LAST_OFF    = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  src_req,
  input  logic [3:0]  en_serial,
  input  logic        en_cmatch,
  input  logic        sw_req,
  input  logic [7:0]  sw_vec,
  input  logic [15:0] base_hi,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ready,
  input  logic [15:0] mem_rdata,
  output logic        desc_valid,
  output logic        desc_err,
  output logic [2:0]  desc_origin,
  output logic [15:0] desc_mode,
  output logic [15:0] desc_cnt_a,
  output logic [15:0] desc_cnt_b,
  output logic [31:0] desc_init,
  output logic [31:0] desc_src_addr,
  output logic [31:0] desc_dst_addr
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LAST_OFF);

  seq_state_e       state;
  logic [SRC_W-1:0] src_q;
  logic [15:0]      vaddr_q;
  logic [15:0]      base_q;
  logic [31:0]      start_q;
  logic [OFF_W-1:0] off_q;
  logic             valid_q, err_q;

  logic [N_HW-1:0]  gate;
  logic             any_req;
  logic [SRC_W-1:0] win;
  logic [1:0]       mode_bits;

  // Named internal events
  logic vec_phase, desc_phase, hs, accept, pulse_busy, bad_mode, last_word;
  logic [1:0] cur_mode;

  assign gate = {en_cmatch, en_serial[0], en_serial[1], en_serial[2], en_serial[3]};

  xds_arbiter #(.N(N_HW)) u_arb (
    .req    (src_req),
    .gate   (gate),
    .sw_req (sw_req),
    .any    (any_req),
    .win    (win)
  );

  assign vec_phase  = (state == ST_VEC);
  assign desc_phase = (state == ST_DESC);
  assign mem_req    = vec_phase | desc_phase;
  assign hs         = mem_req & mem_ready;
  assign pulse_busy = valid_q | err_q;
  assign accept     = (state == ST_IDLE) & any_req & ~pulse_busy;
  assign cur_mode   = (off_q == '0) ? mem_rdata[1:0] : mode_bits;
  assign bad_mode   = desc_phase & hs & (off_q == '0) & (mem_rdata[1:0] == M_BAD);
  assign last_word  = desc_phase & hs & (off_q == LAST);

  always_comb begin
    if (vec_phase) mem_addr = {16'h0000, vaddr_q};
    else           mem_addr = start_q + {{(32-OFF_W){1'b0}}, off_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      src_q   <= '0;
      vaddr_q <= '0;
      base_q  <= '0;
      start_q <= '0;
      off_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_VEC;
            src_q   <= win;
            vaddr_q <= vec_addr(win, sw_vec, VEC_HW_BASE, VEC_SW_BASE);
            base_q  <= base_hi;
          end
        end
        ST_VEC: begin
          if (hs) begin
            start_q <= {base_q, mem_rdata};
            off_q   <= '0;
            state   <= ST_DESC;
          end
        end
        ST_DESC: begin
          if (bad_mode) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end else if (last_word) begin
            valid_q <= 1'b1;
            state   <= ST_IDLE;
          end else if (hs) begin
            off_q <= next_off(cur_mode, off_q);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  xds_fields u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .wr        (desc_phase & hs),
    .off       (off_q),
    .wdata     (mem_rdata),
    .mode_bits (mode_bits),
    .f_mode    (desc_mode),
    .f_cnt_a   (desc_cnt_a),
    .f_cnt_b   (desc_cnt_b),
    .f_init    (desc_init),
    .f_src     (desc_src_addr),
    .f_dst     (desc_dst_addr)
  );

  assign desc_valid  = valid_q;
  assign desc_err    = err_q;
  assign desc_origin = src_q;
endmodule

// File: rtl/xds_checker.sv
module xds_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        desc_valid,
  input logic        desc_err,
  input logic [15:0] desc_mode,
  input logic [15:0] desc_cnt_b,
  input logic [31:0] desc_init,
  input logic        vec_phase
);
  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_valid && desc_err));

  p_no_bad_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_mode[1:0] != 2'b11));

  p_quiet_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid || desc_err) |-> !mem_req);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> !desc_valid);

  p_vec_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_phase |-> (mem_addr[31:16] == 16'h0000 && mem_addr[15:8] == 8'h04));

  p_init_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_mode[1:0] != 2'b01) |-> (desc_init == 32'h0));

  p_cntb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_mode[1:0] != 2'b10) |-> (desc_cnt_b == 16'h0));
endmodule

bind xds_seq xds_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .desc_valid (desc_valid),
  .desc_err   (desc_err),
  .desc_mode  (desc_mode),
  .desc_cnt_b (desc_cnt_b),
  .desc_init  (desc_init),
  .vec_phase  (vec_phase)
);

// File: tb/tb_xds_seq.sv
module tb_xds_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_req = '0;
  logic [3:0]  en_serial = 4'hF;
  logic        en_cmatch = 1'b1;
  logic        sw_req = 1'b0;
  logic [7:0]  sw_vec = '0;
  logic [15:0] base_hi = 16'h0001;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        desc_valid, desc_err;
  logic [2:0]  desc_origin;
  logic [15:0] desc_mode, desc_cnt_a, desc_cnt_b;
  logic [31:0] desc_init, desc_src_addr, desc_dst_addr;

  int nchk = 0, nfail = 0, cyc = 0;
  int seed = 7;
  logic [31:0] exp_q[$];
  logic [15:0] mem [int];

  always #2.5 clk = ~clk;

  xds_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 16'h0000;
  endfunction

  // Memory responder with random latency; checks every accepted address.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
    end else begin
      seed = seed * 1103515245 + 12345;
      if (mem_req && seed[20]) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected read", mem_addr, 32'hFFFFFFFF);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(mem_addr == e, "R3-walk address order", mem_addr, e);
        end
        mem_rdata = rd(mem_addr);
        mem_ready = 1'b1;
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic put_desc(input logic [31:0] s, input logic [15:0] mw, input logic [15:0] ca,
                          input logic [31:0] init, input logic [15:0] cb,
                          input logic [31:0] sa, input logic [31:0] da);
    mem[int'(s)]      = mw;
    mem[int'(s + 2)]  = ca;
    mem[int'(s + 4)]  = init[31:16];
    mem[int'(s + 6)]  = (mw[1:0] == 2'b10) ? cb : init[15:0];
    mem[int'(s + 8)]  = sa[31:16];
    mem[int'(s + 10)] = sa[15:0];
    mem[int'(s + 12)] = da[31:16];
    mem[int'(s + 14)] = da[15:0];
  endtask

  // Reference model for one activation: builds the expected read order and fields.
  task automatic expect_act(input int src, input logic [15:0] va, input logic [15:0] bh);
    logic [31:0] st, e_init, e_sa, e_da;
    logic [15:0] mw, e_cb;
    logic [1:0]  md;
    string tg;
    int t;
    exp_q.push_back({16'h0, va});
    st = {bh, rd({16'h0, va})};
    mw = rd(st);
    md = mw[1:0];
    exp_q.push_back(st);
    if (md != 2'b11) begin
      exp_q.push_back(st + 2);
      if (md == 2'b01) begin exp_q.push_back(st + 4); exp_q.push_back(st + 6); end
      if (md == 2'b10) exp_q.push_back(st + 6);
      for (int k = 8; k <= 14; k += 2) exp_q.push_back(st + k);
    end
    e_init = (md == 2'b01) ? {rd(st + 4), rd(st + 6)} : 32'h0;
    e_cb   = (md == 2'b10) ? rd(st + 6) : 16'h0;
    e_sa   = {rd(st + 8), rd(st + 10)};
    e_da   = {rd(st + 12), rd(st + 14)};
    tg = (md == 2'b00) ? "R4" : (md == 2'b01) ? "R5" : "R6";
    t = 0;
    while (!(desc_valid || desc_err) && t < 400) begin
      @(negedge clk);
      t++;
      chk(!(desc_valid && md == 2'b11), "R8 valid on bad mode", {31'h0, desc_valid}, 32'h0);
    end
    chk(t < 400, "R10 pulse timeout", t, 400);
    chk(mem_req == 1'b0, "R10 mem_req during pulse", {31'h0, mem_req}, 32'h0);
    chk(exp_q.size() == 0, "R8/R4 reads left over", exp_q.size(), 0);
    exp_q.delete();
    if (md == 2'b11) begin
      chk(desc_err && !desc_valid, "R8 error pulse", {30'h0, desc_err, desc_valid}, 32'h2);
    end else begin
      chk(desc_valid && !desc_err, {tg, " valid pulse"}, {30'h0, desc_err, desc_valid}, 32'h1);
      chk(desc_origin == 3'(src), "R1 origin", desc_origin, src);
      chk(desc_mode == mw, "R7 mode word", desc_mode, mw);
      chk(desc_cnt_a == rd(st + 2), "R7 count A", desc_cnt_a, rd(st + 2));
      chk(desc_init == e_init, {tg, " R7 init field"}, desc_init, e_init);
      chk(desc_cnt_b == e_cb, {tg, " R7 count B"}, desc_cnt_b, e_cb);
      chk(desc_src_addr == e_sa, "R7 source address", desc_src_addr, e_sa);
      chk(desc_dst_addr == e_da, "R7 dest address", desc_dst_addr, e_da);
    end
    @(negedge clk);
    chk(!desc_valid && !desc_err, "R10 single pulse", {30'h0, desc_err, desc_valid}, 32'h0);
  endtask

  initial begin
    int busy;
    // vector table and descriptors
    mem[32'h438] = 16'h1000;
    mem[32'h43A] = 16'h1100;
    mem[32'h43C] = 16'h1200;
    mem[32'h43E] = 16'h1300;
    mem[32'h440] = 16'h1400;
    mem[32'h405] = 16'h1500;
    put_desc(32'h0001_1000, 16'h0A80, 16'h0010, 32'hDEADBEEF, 16'h0, 32'hAAAA0001, 32'hBBBB0002);
    put_desc(32'h0001_1100, 16'h0043, 16'h0011, 32'h0, 16'h0, 32'h1, 32'h2);
    put_desc(32'h0001_1200, 16'h0E82, 16'h0012, 32'hFEED0000, 16'h0034, 32'hCCCC0003, 32'hDDDD0004);
    put_desc(32'h0001_1300, 16'h0C41, 16'h0013, 32'h12345678, 16'h0, 32'hEEEE0005, 32'hFFFF0006);
    put_desc(32'h0001_1400, 16'h0E82, 16'h0014, 32'hCAFE0000, 16'h0099, 32'h01010007, 32'h02020008);
    put_desc(32'h0002_1500, 16'h0F00, 16'h0015, 32'hDEADBEEF, 16'h0, 32'h03030009, 32'h0404000A);
    put_desc(32'h0001_1500, 16'h0003, 16'h0, 32'h0, 16'h0, 32'h0, 32'h0);

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(!mem_req && !desc_valid && !desc_err, "R11 control outputs", {29'h0, mem_req, desc_valid, desc_err}, 0);
    chk(desc_mode == 0 && desc_cnt_a == 0 && desc_cnt_b == 0 && desc_init == 0 &&
        desc_src_addr == 0 && desc_dst_addr == 0, "R11 fields zero", desc_src_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 normal mode, serial 0 receive
    src_req = 5'b00001; expect_act(0, 16'h0438, 16'h0001); src_req = '0;
    // R5 repeat mode, serial 1 transmit
    src_req = 5'b01000; expect_act(3, 16'h043E, 16'h0001); src_req = '0;
    // R6 block mode, compare-match
    src_req = 5'b10000; expect_act(4, 16'h0440, 16'h0001); src_req = '0;
    // R3 software, odd vector value, other base
    base_hi = 16'h0002; sw_vec = 8'h05; sw_req = 1'b1;
    expect_act(5, 16'h0405, 16'h0002); sw_req = 1'b0; base_hi = 16'h0001;
    // R8 bad mode, serial 0 transmit
    src_req = 5'b00010; expect_act(1, 16'h043A, 16'h0001); src_req = '0;

    // R1 all at once, drop the winner each time
    src_req = 5'b11111; sw_req = 1'b1; sw_vec = 8'h05; base_hi = 16'h0001;
    for (int i = 0; i < 5; i++) begin
      expect_act(i, 16'h0438 + 16'(2 * i), 16'h0001);
      src_req[i] = 1'b0;
    end
    expect_act(5, 16'h0405, 16'h0001); sw_req = 1'b0;

    // R2 enable gating
    en_serial[3] = 1'b0;
    src_req = 5'b00101; expect_act(2, 16'h043C, 16'h0001); src_req[2] = 1'b0;
    busy = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) busy++; end
    chk(busy == 0, "R2 disabled request ignored", busy, 0);
    en_cmatch = 1'b0; src_req = 5'b10001; sw_req = 1'b1; sw_vec = 8'h05;
    expect_act(5, 16'h0405, 16'h0001); sw_req = 1'b0;
    busy = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) busy++; end
    chk(busy == 0, "R2 compare-match gated", busy, 0);
    en_serial[3] = 1'b1;
    expect_act(0, 16'h0438, 16'h0001); src_req = '0;

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && !mem_req, "R9 idle at end", {31'h0, mem_req}, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule